// File: doc/BRIEF.md
# Triggered Quadrature Position Sampler

This block follows an incremental encoder that delivers two quadrature lines, A and B, and keeps a signed position count that moves by one for every edge seen on either line. Both lines are brought into the clock domain through two-flop synchronisers. Each line then passes a glitch filter whose length is set at run time. Edges on the lines may arrive at 5 MHz and, given a short filter setting, at up to 15 MHz.

The position is not streamed. A rising edge on the trigger input, which belongs to the same clock domain, takes a snapshot of three values: the position count, a free-running 64-bit timestamp and a per-run frame number. The snapshot is queued in a small FIFO and leaves the block on a ready/valid record port. Downstream logic uses the frame number to see missing records, including a missing first record. A clear-readout strobe, raised at configure or at end of run, empties the queue and starts numbering from zero again. It leaves the position count alone.

Top module: `quad_trig_sampler`

## Requirements
- R1: After reset the record port is empty (`rec_valid` low), `drop_count` is 0, `seq_err` is 0 and the position count is 0.
- R2: Writing the line state as {A,B}, each step of the sequence 00→10→11→01→00 adds one to the position count.
- R3: Each step of the reverse sequence 00→01→11→10→00 subtracts one. The count is 32-bit two's complement, so it goes below zero (−3 reads 0xFFFFFFFD).
- R4: When A and B change in the same cycle after filtering, the count stays the same and `seq_err` goes to 1. It then stays at 1 until a clear-readout.
- R5: A new level on a line is accepted only after it has been stable for `glitch_len`+1 consecutive cycles at the synchroniser output. A shorter pulse has no effect.
- R6: A rising edge of `trig` captures the position, the timestamp and the frame number into one record. The timestamp equals the number of clock cycles since reset was released, counted up to that edge. Holding `trig` high yields only one record.
- R7: The frame number is 0 for the first trigger after reset or after a clear-readout. It rises by one on every trigger edge.
- R8: A trigger that arrives while the FIFO holds `DEPTH` records is discarded and `drop_count` rises by one. The frame number still advances, so the next stored record shows a gap.
- R9: Records leave in the order they were captured. While `rec_valid` is high and `rec_ready` is low, the head record is held unchanged.
- R10: `clr_readout` empties the FIFO, sets the frame number back to 0 and clears `drop_count` and `seq_err`. A trigger edge in the same cycle is ignored. The position count is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the block, the trigger and the timestamp |
| rst_n | input | 1 | Synchronous reset, active low |
| enc_a | input | 1 | Encoder line A, asynchronous |
| enc_b | input | 1 | Encoder line B, asynchronous |
| glitch_len | input | FLT_W | Filter length: a level must hold glitch_len+1 cycles |
| trig | input | 1 | Capture request; the rising edge is used |
| clr_readout | input | 1 | Flush queue, restart frame numbers, clear error and drop count |
| rec_ready | input | 1 | Consumer accepts the head record |
| rec_valid | output | 1 | A record is available |
| rec_pos | output | POS_W | Captured signed position |
| rec_ts | output | TS_W | Captured timestamp |
| rec_frame | output | FRAME_W | Captured frame number |
| drop_count | output | DROP_W | Triggers lost to a full queue since the last clear |
| seq_err | output | 1 | Sticky flag for an illegal two-line transition |

## Verification
The bench drives both encoder directions and takes the count below zero. A design that swapped the sense of direction, or that saturated instead of using two's complement, would report the wrong position in the captured record. A two-line change is driven at the filter boundary: a pulse of `glitch_len` cycles must leave `seq_err` low and one of `glitch_len`+1 cycles must set it, so an off-by-one filter is exposed in either direction. With the consumer stalled, the bench fills the queue and sends two more triggers. A design that overwrote the queue, failed to count the drops or held the frame number during a drop would deliver the wrong frames once the consumer resumes. Last, a clear-readout is raised together with a trigger while records are pending. A design that let the trigger through, kept stale records or lost the position would leave a record behind or mislabel the next one.

// File: rtl/quad_trig_sampler.sv
module quad_trig_sampler #(
  parameter int POS_W   = 32,
  parameter int TS_W    = 64,
  parameter int FRAME_W = 32,
  parameter int DROP_W  = 16,
  parameter int DEPTH   = 8,
  parameter int FLT_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enc_a,
  input  logic               enc_b,
  input  logic [FLT_W-1:0]   glitch_len,
  input  logic               trig,
  input  logic               clr_readout,
  input  logic               rec_ready,
  output logic               rec_valid,
  output logic [POS_W-1:0]   rec_pos,
  output logic [TS_W-1:0]    rec_ts,
  output logic [FRAME_W-1:0] rec_frame,
  output logic [DROP_W-1:0]  drop_count,
  output logic               seq_err
);

  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int REC_W = POS_W + TS_W + FRAME_W;
  localparam logic [AW:0]      FULL_GAP  = {1'b1, {AW{1'b0}}};
  localparam logic [AW:0]      PTR_ONE   = 1;
  localparam logic [POS_W-1:0] POS_ONE   = 1;
  localparam logic [TS_W-1:0]  TS_ONE    = 1;
  localparam logic [FRAME_W-1:0] FRM_ONE = 1;
  localparam logic [DROP_W-1:0] DRP_ONE  = 1;
  localparam logic [FLT_W-1:0] FLT_ONE   = 1;

  // input conditioning
  logic [1:0] sync1, sync2, flt, prev;
  logic [FLT_W-1:0] fcnt [2];
  logic [1:0] prime;
  logic primed;

  assign primed = (prime == 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= 2'b00;
      sync2 <= 2'b00;
      prime <= 2'd0;
    end else begin
      sync1 <= {enc_a, enc_b};
      sync2 <= sync1;
      if (!primed) prime <= prime + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flt  <= 2'b00;
      prev <= 2'b00;
      for (int i = 0; i < 2; i++) fcnt[i] <= '0;
    end else if (!primed) begin
      flt  <= sync2;
      prev <= sync2;
      for (int i = 0; i < 2; i++) fcnt[i] <= '0;
    end else begin
      prev <= flt;
      for (int i = 0; i < 2; i++) begin
        if (sync2[i] == flt[i]) begin
          fcnt[i] <= '0;
        end else if (fcnt[i] >= glitch_len) begin
          flt[i]  <= sync2[i];
          fcnt[i] <= '0;
        end else begin
          fcnt[i] <= fcnt[i] + FLT_ONE;
        end
      end
    end
  end

  // x4 decoder: phase index {B, A^B} runs 0,1,2,3 in the forward direction
  logic [1:0] idx_now, idx_old, dstep;
  logic [POS_W-1:0] pos;

  assign idx_now = {flt[0], flt[1] ^ flt[0]};
  assign idx_old = {prev[0], prev[1] ^ prev[0]};
  assign dstep   = idx_now - idx_old;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos <= '0;
    end else if (primed) begin
      if (dstep == 2'd1)      pos <= pos + POS_ONE;
      else if (dstep == 2'd3) pos <= pos - POS_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_readout) seq_err <= 1'b0;
    else if (primed && dstep == 2'd2) seq_err <= 1'b1;
  end

  // trigger capture
  logic trig_d, trig_rise;
  logic [TS_W-1:0] ts;
  logic [FRAME_W-1:0] frame;

  assign trig_rise = trig && !trig_d && !clr_readout;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_d <= 1'b0;
      ts     <= '0;
    end else begin
      trig_d <= trig;
      ts     <= ts + TS_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_readout) frame <= '0;
    else if (trig_rise)        frame <= frame + FRM_ONE;
  end

  // record queue
  logic [REC_W-1:0] mem [DEPTH];
  logic [AW:0] wr_ptr, rd_ptr;
  logic full, push, pop;

  assign full      = ((wr_ptr ^ rd_ptr) == FULL_GAP);
  assign rec_valid = (wr_ptr != rd_ptr);
  assign push      = trig_rise && !full;
  assign pop       = rec_valid && rec_ready && !clr_readout;
  assign {rec_pos, rec_ts, rec_frame} = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr[AW-1:0]] <= {pos, ts, frame};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_readout) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      drop_count <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + PTR_ONE;
      if (pop)  rd_ptr <= rd_ptr + PTR_ONE;
      if (trig_rise && full) drop_count <= drop_count + DRP_ONE;
    end
  end

  p_pos_unit_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pos == $past(pos) || pos == $past(pos) + POS_ONE || pos == $past(pos) - POS_ONE));

  p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_err && !clr_readout) |=> seq_err);

  p_frame_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_readout |=> (frame == '0));

  p_drop_on_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_rise && full) |=> (drop_count == $past(drop_count) + DRP_ONE) && rec_valid);

  p_hold_stalled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_ready && !clr_readout) |=>
      (rec_valid && $stable(rec_pos) && $stable(rec_ts) && $stable(rec_frame)));

  p_clear_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_readout |=> (!rec_valid && drop_count == '0 && !seq_err));

endmodule

// File: tb/quad_trig_sampler_tb_top.sv
`timescale 1ns/1ps
module quad_trig_sampler_tb_top;
  localparam int DEPTH = 8;

  typedef struct {
    logic [31:0] pos;
    logic [63:0] ts;
    logic [31:0] frame;
    string       tag;
  } exp_rec_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enc_a = 1'b0, enc_b = 1'b0;
  logic [3:0] glitch_len = 4'd0;
  logic trig = 1'b0, clr_readout = 1'b0, rec_ready = 1'b0;
  logic rec_valid, seq_err;
  logic [31:0] rec_pos, rec_frame;
  logic [63:0] rec_ts;
  logic [15:0] drop_count;

  quad_trig_sampler #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
    .glitch_len(glitch_len), .trig(trig), .clr_readout(clr_readout),
    .rec_ready(rec_ready), .rec_valid(rec_valid), .rec_pos(rec_pos),
    .rec_ts(rec_ts), .rec_frame(rec_frame), .drop_count(drop_count),
    .seq_err(seq_err));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [63:0] cyc = 0;
  int exp_pos = 0, exp_frame = 0, exp_occ = 0;
  exp_rec_t q[$];

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (int'(glitch_len) + 8) @(negedge clk);
  endtask

  task automatic step(input bit fwd, input int n);
    for (int k = 0; k < n; k++) begin
      logic [1:0] ix;
      ix = {enc_b, enc_a ^ enc_b};
      ix = fwd ? ix + 2'd1 : ix - 2'd1;
      @(negedge clk);
      enc_b = ix[1];
      enc_a = ix[0] ^ ix[1];
      exp_pos += fwd ? 1 : -1;
      settle();
    end
  endtask

  task automatic fire(input string tag, input int hold);
    exp_rec_t e;
    @(negedge clk);
    e.pos = exp_pos; e.ts = cyc; e.frame = exp_frame; e.tag = tag;
    trig = 1'b1;
    if (exp_occ < DEPTH) begin q.push_back(e); exp_occ++; end
    exp_frame++;
    repeat (hold) @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr_readout = 1'b1;
    @(negedge clk);
    clr_readout = 1'b0;
    q.delete();
    exp_frame = 0;
    exp_occ = 0;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && rec_valid && rec_ready && !clr_readout) begin
        if (q.size() == 0) begin
          chk(0, "R9 unexpected record", {32'd0, rec_frame}, 64'd0);
        end else begin
          exp_rec_t e;
          e = q.pop_front();
          exp_occ--;
          chk(rec_pos == e.pos, {e.tag, " position"}, {32'd0, rec_pos}, {32'd0, e.pos});
          chk(rec_ts == e.ts, {"R6 timestamp/", e.tag}, rec_ts, e.ts);
          chk(rec_frame == e.frame, {"R7 frame/", e.tag}, {32'd0, rec_frame}, {32'd0, e.frame});
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : driver
    logic [31:0] held;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(rec_valid == 1'b0, "R1 valid", rec_valid, 0);
    chk(drop_count == 16'd0, "R1 drops", drop_count, 0);
    chk(seq_err == 1'b0, "R1 seq_err", seq_err, 0);
    rec_ready = 1'b1;
    fire("R1 pos", 1);
    settle();

    step(1'b1, 5);
    fire("R2 forward", 1);
    settle();

    step(1'b0, 8);
    fire("R3 reverse negative", 1);
    settle();

    fire("R6 held trigger", 4);
    settle();
    chk(q.size() == 0 && rec_valid == 1'b0, "R6 one record per edge", rec_valid, 0);

    @(negedge clk);
    enc_a = ~enc_a; enc_b = ~enc_b;
    settle();
    chk(seq_err == 1'b1, "R4 seq_err set", seq_err, 1);
    fire("R4 count unchanged", 1);
    settle();
    step(1'b1, 2);
    chk(seq_err == 1'b1, "R4 sticky", seq_err, 1);

    do_clear();
    chk(seq_err == 1'b0, "R10 seq_err cleared", seq_err, 0);
    fire("R10 position kept", 1);
    settle();

    glitch_len = 4'd3;
    settle();
    @(negedge clk);
    enc_a = ~enc_a; enc_b = ~enc_b;
    repeat (3) @(negedge clk);
    enc_a = ~enc_a; enc_b = ~enc_b;
    settle();
    chk(seq_err == 1'b0, "R5 short pulse rejected", seq_err, 0);
    step(1'b1, 3);
    fire("R5 filtered steps", 1);
    settle();
    @(negedge clk);
    enc_a = ~enc_a; enc_b = ~enc_b;
    repeat (4) @(negedge clk);
    enc_a = ~enc_a; enc_b = ~enc_b;
    settle();
    chk(seq_err == 1'b1, "R5 pulse at threshold accepted", seq_err, 1);
    glitch_len = 4'd0;
    do_clear();

    rec_ready = 1'b0;
    for (int k = 0; k < DEPTH + 2; k++) fire("R8 fill", 1);
    repeat (3) @(negedge clk);
    chk(drop_count == 16'd2, "R8 drop count", drop_count, 2);
    chk(rec_valid == 1'b1, "R9 valid while stalled", rec_valid, 1);
    held = rec_frame;
    repeat (4) @(negedge clk);
    chk(rec_frame == held && held == 32'd0, "R9 head held", rec_frame, 0);
    rec_ready = 1'b1;
    repeat (DEPTH + 4) @(negedge clk);
    chk(q.size() == 0, "R9 all drained", q.size(), 0);
    fire("R8 frame gap", 1);
    settle();

    rec_ready = 1'b0;
    for (int k = 0; k < 3; k++) fire("R10 pending", 1);
    @(negedge clk);
    clr_readout = 1'b1;
    trig = 1'b1;
    @(negedge clk);
    clr_readout = 1'b0;
    trig = 1'b0;
    q.delete(); exp_frame = 0; exp_occ = 0;
    @(negedge clk);
    chk(rec_valid == 1'b0, "R10 queue empty", rec_valid, 0);
    chk(drop_count == 16'd0, "R10 drops cleared", drop_count, 0);
    rec_ready = 1'b1;
    step(1'b0, 2);
    fire("R10 frame restart", 1);
    settle();
    chk(q.size() == 0, "R9 scoreboard empty", q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule